// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block generates the column address for every beat of one SDRAM read or write burst. A controller loads a small mode register that sets the burst length, the beat ordering and whether writes are limited to one location. It then pulses a start strobe together with the first column and a read/write flag. From the next clock the block presents one column per beat and steps to the next beat on every clock where the advance enable is high. It flags the final beat of a finite burst.

A stop strobe ends a burst at once, whatever its length. A new start also replaces a running burst, so a controller can issue a column command on every clock. The burst settings are captured when a burst starts. A mode write that lands during a burst therefore only affects bursts that start afterwards. A full-page burst covers all 256 columns, wraps from the top column to zero, and runs until a stop or a new start ends it.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset `col_vld`, `col_last` and `col` are 0. The mode register resets to 0, which gives length 1, sequential order and bursting writes.
- R2: One clock after an edge with `start` high, `col_vld` is 1 and `col` equals the sampled `start_col`. This is beat 0.
- R3: The beat count steps only at edges where `col_vld` and `adv` are both high. While `adv` is low, `col` and `col_vld` hold their values.
- R4: The mode register is `mode_wdata[4:0]`, loaded at an edge with `mode_we` high. Bits [2:0] give the length: 0 selects 1 beat, 1 selects 2, 2 selects 4, 3 selects 8 and 7 selects full page. With bit 3 at 0 (sequential), beat b of a burst of length L puts `(start_col + b) mod L` on the low log2(L) column bits. The upper bits stay those of `start_col`.
- R5: With bit 3 at 1 (interleaved) and a finite length L, beat b gives `start_col XOR b` on the low log2(L) bits. The upper bits stay those of `start_col`.
- R6: Length code 7 counts `start_col + b` modulo 256. It wraps from 255 to 0, ignores bit 3, never raises `col_last`, and stays valid until a stop or a new start.
- R7: `col_last` is 1 exactly on beat L-1 of a finite burst. Advancing past that beat clears `col_vld` on the next clock.
- R8: One clock after an edge with `stop` high and `start` low, `col_vld`, `col_last` and `col` are 0. If `start` and `stop` are both high at the same edge, `start` wins.
- R9: A `start` during a running burst replaces that burst from the next clock, with beat 0 at the new column.
- R10: When mode bit 4 is 1, a burst started with `start_wr` high is one beat long, while reads keep the programmed length. When bit 4 is 0, writes use the programmed length.
- R11: A mode write affects only bursts started at later edges. A running burst keeps the length and order it started with.
- R12: The unused length codes 4, 5 and 6 give a one-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Loads the mode register |
| mode_wdata | input | 5 | Mode value: [2:0] length code, [3] interleave, [4] single-location write |
| start | input | 1 | Begins a new burst |
| start_col | input | COL_W (8) | First column of the burst |
| start_wr | input | 1 | The burst being started is a write |
| stop | input | 1 | Ends the running burst |
| adv | input | 1 | Step to the next beat this clock |
| col | output | COL_W (8) | Column of the current beat, 0 when idle |
| col_vld | output | 1 | A burst beat is being presented |
| col_last | output | 1 | Current beat is the final beat of a finite burst |

## Verification
Every result is due one clock after the edge that samples its cause. A start, stop, advance or mode write at one rising edge shows up on `col`, `col_vld` and `col_last` right after that edge. No extra register sits between the state and the ports. The bench changes inputs at the falling edge and reads the outputs at the next falling edge, so each check sees the state produced by exactly one rising edge. A mode write is followed by one idle clock before the start, which keeps the case where both land at the same edge out of the vector loop. Held advance, preemption, a same-edge start and stop, and a mode change during a burst are each tested directly, with the expected value checked on the clock where it is due.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

   localparam int MODE_W  = 5;
   localparam int LEN_W   = 3;
   localparam int ILV_BIT = 3;
   localparam int SWR_BIT = 4;

   typedef enum logic [LEN_W-1:0] {
      LEN_1    = 3'd0,
      LEN_2    = 3'd1,
      LEN_4    = 3'd2,
      LEN_8    = 3'd3,
      LEN_PAGE = 3'd7
   } len_code_e;

   typedef enum logic {
      ORDER_SEQ = 1'b0,
      ORDER_ILV = 1'b1
   } order_e;

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
   import sdram_colgen_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_data,
   output logic [COL_W-1:0]  len_mask_o,
   output logic              page_o,
   output logic              ilv_o,
   output logic              single_wr_o
);

   logic [MODE_W-1:0] mode_q;
   len_code_e         len_code;
   order_e            order;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (wr_en) begin
         mode_q <= wr_data;
      end
   end

   assign len_code    = len_code_e'(mode_q[LEN_W-1:0]);
   assign order       = order_e'(mode_q[ILV_BIT]);
   assign single_wr_o = mode_q[SWR_BIT];
   assign ilv_o       = (order == ORDER_ILV);

   always_comb begin
      page_o     = 1'b0;
      len_mask_o = '0;
      case (len_code)
         LEN_1:    len_mask_o = '0;
         LEN_2:    len_mask_o = COL_W'(1);
         LEN_4:    len_mask_o = COL_W'(3);
         LEN_8:    len_mask_o = COL_W'(7);
         LEN_PAGE: begin
            len_mask_o = '1;
            page_o     = 1'b1;
         end
         default:  len_mask_o = '0;
      endcase
   end

   // R12
   reserved_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[LEN_W-1:0] inside {3'd4, 3'd5, 3'd6}) |-> (len_mask_o == '0 && !page_o));

endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  logic             start_wr,
   input  logic             stop,
   input  logic             adv,
   input  logic [COL_W-1:0] rd_mask,
   input  logic             rd_page,
   input  logic             rd_ilv,
   input  logic             single_wr,
   output logic             vld_o,
   output logic [COL_W-1:0] base_o,
   output logic [COL_W-1:0] beat_o,
   output logic [COL_W-1:0] mask_o,
   output logic             page_o,
   output logic             ilv_o,
   output logic             last_o
);

   logic             force_one;
   logic [COL_W-1:0] eff_mask;
   logic             eff_page;
   logic             eff_ilv;

   assign force_one = start_wr & single_wr;
   assign eff_mask  = force_one ? '0 : rd_mask;
   assign eff_page  = rd_page & ~force_one;
   assign eff_ilv   = rd_ilv & ~eff_page & ~force_one;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         base_o <= '0;
         beat_o <= '0;
         mask_o <= '0;
         page_o <= 1'b0;
         ilv_o  <= 1'b0;
      end else if (start) begin
         vld_o  <= 1'b1;
         base_o <= start_col;
         beat_o <= '0;
         mask_o <= eff_mask;
         page_o <= eff_page;
         ilv_o  <= eff_ilv;
      end else if (stop) begin
         vld_o  <= 1'b0;
      end else if (vld_o && adv) begin
         beat_o <= beat_o + COL_W'(1);
         if (last_o) begin
            vld_o <= 1'b0;
         end
      end
   end

   assign last_o = vld_o & ~page_o & (beat_o == mask_o);

   // R2
   start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (vld_o && beat_o == '0));

   // R8
   stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !start) |=> !vld_o);

   // R7
   last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && adv && !start && !stop) |=> !vld_o);

   // R3
   hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && !adv && !start && !stop) |=> (vld_o && $stable(beat_o)));

   // R10
   single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && start_wr && single_wr) |=> last_o);

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
   parameter int COL_W  = 8,
   parameter bit ILV_EN = 1'b1
) (
   input  logic             vld_i,
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             ilv_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] sum;
   logic [COL_W-1:0] seq_col;
   logic [COL_W-1:0] ilv_col;
   logic             use_ilv;

   assign sum     = base_i + beat_i;
   assign seq_col = (base_i & ~mask_i) | (sum & mask_i);

   if (ILV_EN) begin : g_ilv
      assign ilv_col = base_i ^ (beat_i & mask_i);
      assign use_ilv = ilv_i;
   end else begin : g_seq_only
      assign ilv_col = seq_col;
      assign use_ilv = 1'b0;
   end

   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      assign col_o[i] = vld_i & (use_ilv ? ilv_col[i] : seq_col[i]);
   end

   // R5
   always_comb begin
      ilv_low_chk: assert (!(vld_i && use_ilv) ||
         ((col_o & ~mask_i) == (base_i & ~mask_i)));
   end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
   import sdram_colgen_pkg::*;
#(
   parameter int COL_W  = 8,
   parameter bit ILV_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic              start,
   input  logic [COL_W-1:0]  start_col,
   input  logic              start_wr,
   input  logic              stop,
   input  logic              adv,
   output logic [COL_W-1:0]  col,
   output logic              col_vld,
   output logic              col_last
);

   if (COL_W < 3) begin : g_col_w_chk
      $error("COL_W must be at least 3 to hold an 8-beat burst");
   end

   logic [COL_W-1:0] rd_mask;
   logic             rd_page;
   logic             rd_ilv;
   logic             single_wr;
   logic [COL_W-1:0] base;
   logic [COL_W-1:0] beat;
   logic [COL_W-1:0] mask;
   logic             page;
   logic             ilv;

   burst_mode_reg #(.COL_W(COL_W)) i_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (mode_we),
      .wr_data     (mode_wdata),
      .len_mask_o  (rd_mask),
      .page_o      (rd_page),
      .ilv_o       (rd_ilv),
      .single_wr_o (single_wr)
   );

   burst_beat_ctrl #(.COL_W(COL_W)) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_col (start_col),
      .start_wr  (start_wr),
      .stop      (stop),
      .adv       (adv),
      .rd_mask   (rd_mask),
      .rd_page   (rd_page),
      .rd_ilv    (rd_ilv),
      .single_wr (single_wr),
      .vld_o     (col_vld),
      .base_o    (base),
      .beat_o    (beat),
      .mask_o    (mask),
      .page_o    (page),
      .ilv_o     (ilv),
      .last_o    (col_last)
   );

   burst_col_map #(.COL_W(COL_W), .ILV_EN(ILV_EN)) i_map (
      .vld_i  (col_vld),
      .base_i (base),
      .beat_i (beat),
      .mask_i (mask),
      .ilv_i  (ilv),
      .col_o  (col)
   );

   // R1
   last_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_last |-> col_vld);

   // R6
   page_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_vld && page && !start && !stop) |=> col_vld);

   // R6
   page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_vld && page && adv && !start && !stop && col == '1) |=> (col == '0));

endmodule

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_we = 1'b0;
   logic [4:0] mode_wdata = '0;
   logic       start = 1'b0;
   logic [7:0] start_col = '0;
   logic       start_wr = 1'b0;
   logic       stop = 1'b0;
   logic       adv = 1'b0;
   logic [7:0] col;
   logic       col_vld;
   logic       col_last;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   sdram_burst_colgen i_sdram_burst_colgen (
      .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
      .start(start), .start_col(start_col), .start_wr(start_wr),
      .stop(stop), .adv(adv), .col(col), .col_vld(col_vld), .col_last(col_last)
   );

   typedef struct packed {
      logic [4:0] mode;
      logic [7:0] scol;
      logic       wr;
      logic [8:0] len;
      logic [7:0] col1;
   } vec_t;

   localparam vec_t VECS [11] = '{
      '{5'b00010, 8'h0E, 1'b0, 9'd4, 8'h0F},   // R4 BL4 seq
      '{5'b01010, 8'h0D, 1'b0, 9'd4, 8'h0C},   // R5 BL4 interleave
      '{5'b00011, 8'h35, 1'b0, 9'd8, 8'h36},   // R4 BL8 seq
      '{5'b01011, 8'h35, 1'b0, 9'd8, 8'h34},   // R5 BL8 interleave
      '{5'b00000, 8'h80, 1'b0, 9'd1, 8'h00},   // R4 BL1
      '{5'b00001, 8'h81, 1'b0, 9'd2, 8'h80},   // R4 BL2 seq
      '{5'b10011, 8'h22, 1'b1, 9'd1, 8'h00},   // R10 single write
      '{5'b10011, 8'h22, 1'b0, 9'd8, 8'h23},   // R10 read still bursts
      '{5'b00011, 8'h22, 1'b1, 9'd8, 8'h23},   // R10 write bursts when bit clear
      '{5'b00101, 8'h40, 1'b0, 9'd1, 8'h00},   // R12 reserved code
      '{5'b01110, 8'h47, 1'b0, 9'd1, 8'h00}    // R12 reserved code 6
   };

   function automatic int ref_len(logic [4:0] m, logic wr);
      int l;
      case (m[2:0])
         3'd0: l = 1;
         3'd1: l = 2;
         3'd2: l = 4;
         3'd3: l = 8;
         3'd7: l = 256;
         default: l = 1;
      endcase
      if (wr && m[4]) l = 1;
      return l;
   endfunction

   function automatic logic [7:0] ref_col(logic [4:0] m, logic [7:0] s, logic wr, int b);
      int         l;
      logic [7:0] msk;
      logic [7:0] bb;
      l   = ref_len(m, wr);
      msk = 8'(l - 1);
      bb  = 8'(b);
      if (m[3] && l != 256) return s ^ (bb & msk);
      return (s & ~msk) | ((s + bb) & msk);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_mode(logic [4:0] m);
      mode_we = 1'b1; mode_wdata = m;
      cyc();
      mode_we = 1'b0;
      cyc();
   endtask

   task automatic go(logic [7:0] c, logic wr);
      start = 1'b1; start_col = c; start_wr = wr;
      cyc();
      start = 1'b0; start_wr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      cyc();
      rst_n = 1'b1;
      cyc();
      // R1 reset state
      chk("R1 vld", 32'(col_vld), 0);
      chk("R1 last", 32'(col_last), 0);
      chk("R1 col", 32'(col), 0);
      // R1 reset mode gives one beat
      go(8'h9A, 1'b0);
      chk("R1 col", 32'(col), 32'h9A);
      chk("R1 last", 32'(col_last), 1);
      adv = 1'b1;
      cyc();
      chk("R1 ends", 32'(col_vld), 0);
      adv = 1'b0;

      // vector table walk: R4 R5 R7 R10 R12
      foreach (VECS[i]) begin
         set_mode(VECS[i].mode);
         go(VECS[i].scol, VECS[i].wr);
         adv = 1'b1;
         for (int b = 0; b < int'(VECS[i].len); b++) begin
            chk("R2 vld", 32'(col_vld), 1);
            chk("R4/R5 col", 32'(col), 32'(ref_col(VECS[i].mode, VECS[i].scol, VECS[i].wr, b)));
            chk("R7 last", 32'(col_last), 32'(b == int'(VECS[i].len) - 1));
            if (b == 1) chk("R4/R5 second beat", 32'(col), 32'(VECS[i].col1));
            cyc();
         end
         chk("R7 end", 32'(col_vld), 0);
         adv = 1'b0;
      end

      // R6 full page with interleave bit set
      set_mode(5'b01111);
      go(8'hFE, 1'b0);
      adv = 1'b1;
      for (int b = 0; b < 260; b++) begin
         if (col !== 8'(8'hFE + b) || col_last !== 1'b0 || col_vld !== 1'b1) begin
            chk("R6 page beat", {22'd0, col_vld, col_last, col}, {22'd0, 1'b1, 1'b0, 8'(8'hFE + b)});
         end
         if (b == 2) chk("R6 wrap", 32'(col), 0);
         cyc();
      end
      chk("R6 still valid", 32'(col_vld), 1);
      stop = 1'b1;
      cyc();
      stop = 1'b0; adv = 1'b0;
      chk("R8 stop page", 32'(col_vld), 0);
      chk("R8 col zero", 32'(col), 0);

      // R3 hold with adv low
      set_mode(5'b00010);
      go(8'h10, 1'b0);
      cyc(); cyc(); cyc();
      chk("R3 hold col", 32'(col), 32'h10);
      chk("R3 hold vld", 32'(col_vld), 1);
      adv = 1'b1;
      cyc();
      chk("R3 step", 32'(col), 32'h11);
      // R9 preempt
      start = 1'b1; start_col = 8'h57;
      cyc();
      start = 1'b0;
      chk("R9 new col", 32'(col), 32'h57);
      cyc();
      chk("R9 next", 32'(col), 32'h54);
      // R8 start and stop together
      start = 1'b1; stop = 1'b1; start_col = 8'h20;
      cyc();
      start = 1'b0;
      chk("R8 start wins", 32'(col), 32'h20);
      chk("R8 start wins vld", 32'(col_vld), 1);
      // R8 stop mid burst
      cyc();
      stop = 1'b0; adv = 1'b0;
      chk("R8 stop vld", 32'(col_vld), 0);
      chk("R8 stop last", 32'(col_last), 0);

      // R11 mode write during burst
      set_mode(5'b00011);
      go(8'h00, 1'b0);
      adv = 1'b1;
      cyc();
      mode_we = 1'b1; mode_wdata = 5'b00001;
      cyc();
      mode_we = 1'b0;
      for (int b = 2; b < 8; b++) begin
         chk("R11 keeps length", 32'(col), 32'(b));
         cyc();
      end
      chk("R11 end", 32'(col_vld), 0);
      adv = 1'b0;
      go(8'h06, 1'b0);
      adv = 1'b1;
      cyc();
      chk("R11 new length", 32'(col), 32'h07);
      chk("R11 new last", 32'(col_last), 1);
      adv = 1'b0;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule